// File: doc/BRIEF.md
# Fuse Key Row Gatherer

This block collects a secret key of up to a parameterised number of 32-bit words from a range of one-time-programmable fuse rows. A start pulse captures a first row, a last row and a requested word count. The block then walks the rows in ascending order. It issues one read at a time over a simple request/response interface and waits for each response before it moves on.

A response is used only when its ECC-error flag is clear and all of its fail bits are zero. Any other row is passed over: it gives no word, but the row cursor still moves forward. Each usable row gives its low 32 bits as the next key word, which appears on a word/index/strobe output. While words are gathered, an OR of all accepted words and an AND of all accepted words are kept.

The walk stops when enough words have been gathered or when the cursor has moved past the last row. The block then pulses done with a pass/fail verdict. The verdict is fail when any of these holds:
- the key is blank (the OR is zero);
- the key is all ones (the AND is still all ones);
- the cursor ran past the last row.

The controller is a four-state machine:
- IDLE: waits for start. Start moves it to ISSUE.
- ISSUE: if words are still needed and the cursor is within range, it raises the read request and moves to WAIT. Otherwise it moves to FINISH.
- WAIT: holds until a response arrives, then returns to ISSUE.
- FINISH: produces the verdict and returns to IDLE.

Top module: `fuse_key_gather`

## Requirements
- R1: A start pulse sampled in IDLE makes busy high in the next cycle. A start pulse sampled while busy is ignored: the row sequence, the key words and the verdict of the run in progress are unchanged.
- R2: The first read request carries the start row. Each later request carries the previous row plus one. Requests are single-cycle, only one is outstanding at a time, and none is made for a row beyond the end row or once the word count has been reached.
- R3: A response with the ECC-error flag set, or with any fail bit set, produces no key word, but the next request still moves to the following row.
- R4: A good response produces a one-cycle key-valid strobe in the cycle after the response. The strobe carries the response's low 32 data bits and a word index that starts at 0 and rises by one per emitted word.
- R5: A requested word count above MAX_WORDS is treated as MAX_WORDS. A count of zero makes no reads and ends in fail.
- R6: The verdict is fail when the AND of all accepted words is all ones. This includes the case where no word was accepted.
- R7: The verdict is fail when the OR of all accepted words is zero.
- R8: The verdict is fail when the row cursor has passed the end row as the walk stops. This includes a key whose last word came from the end row itself, and an end row below the start row. The cursor does not wrap at the top of the row space.
- R9: Done is a one-cycle pulse raised in the same cycle busy falls. Pass is valid with done and holds until the next accepted start.
- R10: After reset: busy, done, pass, read request and key-valid are all low.
- R11: Every accepted start reinitialises the cursor, the word counter, the index and both accumulators, so a run's verdict does not depend on earlier runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, acted on only when idle |
| start_row | input | ROW_W | First row to read |
| end_row | input | ROW_W | Last row that may be read |
| num_words | input | CNT_W | Requested key length in words |
| busy | output | 1 | High from the cycle after start until done |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Verdict, valid with done and held afterwards |
| rd_req | output | 1 | Single-cycle row read request |
| rd_row | output | ROW_W | Row addressed by the request |
| rd_valid | input | 1 | Response strobe for the outstanding read |
| rd_data | input | DATA_W | Row data word |
| rd_ecc_err | input | 1 | Uncorrectable ECC flag for the row |
| rd_fail | input | FAIL_W | Per-row fail bits; any nonzero bit marks the row bad |
| key_valid | output | 1 | Key word strobe |
| key_idx | output | IDX_W | Index of the emitted key word |
| key_word | output | DATA_W | Emitted key word |

## Verification
The assertions assume that the fuse side returns exactly one rd_valid for each rd_req, and only after the request, with data, ECC flag and fail bits stable in that cycle. The bench's responder keeps to this. It watches for a request, answers exactly once on the following cycle, and never raises rd_valid at any other time. The assertions also assume that start_row, end_row and num_words are stable when start is sampled. The bench drives them in the same cycle as the start pulse and changes them only together with a new start.

// File: rtl/fkg_pkg.sv
package fkg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } fkg_state_e;

endpackage

// File: rtl/fkg_cursor.sv
module fkg_cursor #(
    parameter int ROW_W     = 10,
    parameter int MAX_WORDS = 16,
    parameter int CNT_W     = 5,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic [ROW_W-1:0] start_row,
    input  logic [ROW_W-1:0] end_row,
    input  logic [CNT_W-1:0] num_words,
    input  logic             step,
    input  logic             take,
    output logic             more,
    output logic             past_end,
    output logic [ROW_W-1:0] row,
    output logic [IDX_W-1:0] idx
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_WORDS);

    // one extra bit so the cursor never wraps at the top row
    logic [ROW_W:0]   row_q;
    logic [ROW_W-1:0] end_q;
    logic [CNT_W-1:0] need_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] need_init;

    assign need_init = (num_words > CNT_MAX) ? CNT_MAX : num_words;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            end_q  <= '0;
            need_q <= '0;
            idx_q  <= '0;
        end else if (init) begin
            row_q  <= {1'b0, start_row};
            end_q  <= end_row;
            need_q <= need_init;
            idx_q  <= '0;
        end else begin
            if (step) begin
                row_q <= row_q + 1'b1;
            end
            if (take) begin
                need_q <= need_q - 1'b1;
                idx_q  <= idx_q + 1'b1;
            end
        end
    end

    assign past_end = row_q > {1'b0, end_q};
    assign more     = (need_q != '0) && !past_end;
    assign row      = row_q[ROW_W-1:0];
    assign idx      = idx_q;

endmodule

// File: rtl/fkg_accum.sv
module fkg_accum #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [DATA_W-1:0] word,
    output logic              and_ones,
    output logic              or_zero
);

    logic [DATA_W-1:0] or_q;
    logic [DATA_W-1:0] and_q;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                or_q[b]  <= 1'b0;
                and_q[b] <= 1'b1;
            end else if (clr) begin
                or_q[b]  <= 1'b0;
                and_q[b] <= 1'b1;
            end else if (en) begin
                or_q[b]  <= or_q[b] | word[b];
                and_q[b] <= and_q[b] & word[b];
            end
        end
    end

    assign and_ones = &and_q;
    assign or_zero  = ~|or_q;

endmodule

// File: rtl/fkg_ctrl.sv
module fkg_ctrl
    import fkg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              more,
    input  logic              past_end,
    input  logic              and_ones,
    input  logic              or_zero,
    input  logic              rsp_valid,
    input  logic              rsp_good,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [IDX_W-1:0]  idx,
    output logic              busy,
    output logic              rd_req,
    output logic              init,
    output logic              step,
    output logic              take,
    output logic              done,
    output logic              pass,
    output logic              key_valid,
    output logic [IDX_W-1:0]  key_idx,
    output logic [DATA_W-1:0] key_word
);

    fkg_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ISSUE;
            ST_ISSUE:  state_d = more ? ST_WAIT : ST_FINISH;
            ST_WAIT:   if (rsp_valid) state_d = ST_ISSUE;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign busy   = (state_q != ST_IDLE);
    assign init   = (state_q == ST_IDLE) && start;
    assign rd_req = (state_q == ST_ISSUE) && more;
    assign step   = (state_q == ST_WAIT) && rsp_valid;
    assign take   = step && rsp_good;

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            pass      <= 1'b0;
            key_valid <= 1'b0;
            key_idx   <= '0;
            key_word  <= '0;
        end else begin
            done      <= 1'b0;
            key_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) pass <= 1'b0;
                end
                ST_WAIT: begin
                    if (rsp_valid && rsp_good) begin
                        key_valid <= 1'b1;
                        key_idx   <= idx;
                        key_word  <= rsp_data;
                    end
                end
                ST_FINISH: begin
                    done <= 1'b1;
                    pass <= !and_ones && !or_zero && !past_end;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fuse_key_gather.sv
module fuse_key_gather #(
    parameter  int ROW_W     = 10,
    parameter  int DATA_W    = 32,
    parameter  int FAIL_W    = 9,
    parameter  int MAX_WORDS = 16,
    localparam int CNT_W     = $clog2(MAX_WORDS + 1),
    localparam int IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  start_row,
    input  logic [ROW_W-1:0]  end_row,
    input  logic [CNT_W-1:0]  num_words,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              rd_req,
    output logic [ROW_W-1:0]  rd_row,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_ecc_err,
    input  logic [FAIL_W-1:0] rd_fail,
    output logic              key_valid,
    output logic [IDX_W-1:0]  key_idx,
    output logic [DATA_W-1:0] key_word
);

    logic init, step, take, more, past_end, and_ones, or_zero, rsp_good;
    logic [IDX_W-1:0] idx;

    assign rsp_good = !rd_ecc_err && (rd_fail == '0);

    fkg_cursor #(
        .ROW_W(ROW_W), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) i_cursor (
        .clk(clk), .rst_n(rst_n), .init(init),
        .start_row(start_row), .end_row(end_row), .num_words(num_words),
        .step(step), .take(take), .more(more), .past_end(past_end),
        .row(rd_row), .idx(idx)
    );

    fkg_accum #(.DATA_W(DATA_W)) i_accum (
        .clk(clk), .rst_n(rst_n), .clr(init), .en(take), .word(rd_data),
        .and_ones(and_ones), .or_zero(or_zero)
    );

    fkg_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .more(more),
        .past_end(past_end), .and_ones(and_ones), .or_zero(or_zero),
        .rsp_valid(rd_valid), .rsp_good(rsp_good), .rsp_data(rd_data),
        .idx(idx), .busy(busy), .rd_req(rd_req), .init(init), .step(step),
        .take(take), .done(done), .pass(pass), .key_valid(key_valid),
        .key_idx(key_idx), .key_word(key_word)
    );

endmodule

// File: rtl/fkg_check.sv
module fkg_check #(
    parameter int ROW_W  = 10,
    parameter int DATA_W = 32,
    parameter int FAIL_W = 9,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              rd_req,
    input logic [ROW_W-1:0]  rd_row,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_ecc_err,
    input logic [FAIL_W-1:0] rd_fail,
    input logic              key_valid,
    input logic [IDX_W-1:0]  key_idx,
    input logic [DATA_W-1:0] key_word
);

    logic             waiting, seen;
    logic [ROW_W-1:0] last_row;
    logic [IDX_W-1:0] exp_idx;
    logic             good;

    assign good = !rd_ecc_err && (rd_fail == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waiting  <= 1'b0;
            seen     <= 1'b0;
            last_row <= '0;
            exp_idx  <= '0;
        end else begin
            if (rd_req) waiting <= 1'b1;
            else if (rd_valid) waiting <= 1'b0;
            if (start && !busy) begin
                seen    <= 1'b0;
                exp_idx <= '0;
            end else begin
                if (rd_req) begin
                    seen     <= 1'b1;
                    last_row <= rd_row;
                end
                if (key_valid) exp_idx <= exp_idx + 1'b1;
            end
        end
    end

    a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    a_r2_rows_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && seen) |-> (rd_row > last_row));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !key_valid));

    a_r3_bad_row_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && rd_valid && !good) |=> !key_valid);

    a_r4_good_row_word: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && rd_valid && good) |=> (key_valid && key_word == $past(rd_data)));

    a_r4_index_order: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> (key_idx == exp_idx));

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(pass));

endmodule

bind fuse_key_gather fkg_check #(
    .ROW_W(ROW_W), .DATA_W(DATA_W), .FAIL_W(FAIL_W), .IDX_W(IDX_W)
) i_fkg_check (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass(pass), .rd_req(rd_req), .rd_row(rd_row), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ecc_err(rd_ecc_err), .rd_fail(rd_fail),
    .key_valid(key_valid), .key_idx(key_idx), .key_word(key_word)
);

// File: tb/test_fuse_key_gather.sv
module test_fuse_key_gather;

    localparam int ROW_W  = 10;
    localparam int DATA_W = 32;
    localparam int FAIL_W = 9;
    localparam int MAXW   = 16;
    localparam int CNT_W  = 5;
    localparam int IDX_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ROW_W-1:0] start_row = '0, end_row = '0;
    logic [CNT_W-1:0] num_words = '0;
    logic busy, done, pass, rd_req, key_valid;
    logic [ROW_W-1:0] rd_row;
    logic rd_valid = 1'b0, rd_ecc_err = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic [FAIL_W-1:0] rd_fail = '0;
    logic [IDX_W-1:0] key_idx;
    logic [DATA_W-1:0] key_word;

    always #10 clk = ~clk;

    fuse_key_gather #(.ROW_W(ROW_W), .DATA_W(DATA_W), .FAIL_W(FAIL_W), .MAX_WORDS(MAXW))
    i_fuse_key_gather (
        .clk(clk), .rst_n(rst_n), .start(start), .start_row(start_row),
        .end_row(end_row), .num_words(num_words), .busy(busy), .done(done),
        .pass(pass), .rd_req(rd_req), .rd_row(rd_row), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_ecc_err(rd_ecc_err), .rd_fail(rd_fail),
        .key_valid(key_valid), .key_idx(key_idx), .key_word(key_word)
    );

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] w;
    } key_item_t;

    key_item_t exp_keys[$];
    int        exp_rows[$];

    logic [DATA_W-1:0] m_dat  [0:63];
    logic              m_ecc  [0:63];
    logic [FAIL_W-1:0] m_fail [0:63];

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // responder: one answer per request, one cycle later
    initial begin
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (rst_n && rd_req) begin
                if (exp_rows.size() == 0) begin
                    chk(1'b0, "R2", "unexpected row request", rd_row, 0);
                end else begin
                    int er;
                    er = exp_rows.pop_front();
                    chk(rd_row == ROW_W'(er), "R2", "row order", rd_row, er);
                end
                @(negedge clk);
                rd_valid   = 1'b1;
                rd_data    = m_dat[rd_row[5:0]];
                rd_ecc_err = m_ecc[rd_row[5:0]];
                rd_fail    = m_fail[rd_row[5:0]];
            end
        end
    end

    // monitor: compare emitted key words against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && key_valid) begin
                if (exp_keys.size() == 0) begin
                    chk(1'b0, "R4", "unexpected key word", key_word, 0);
                end else begin
                    key_item_t e;
                    e = exp_keys.pop_front();
                    chk(key_word == e.w, "R4", "key word", key_word, e.w);
                    chk(key_idx == e.idx, "R4", "key index", key_idx, e.idx);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic run_case(input int srow, input int erow, input int nw,
                            input string vtag, input bit mid_start);
        int row, need, idx, cnt;
        logic [DATA_W-1:0] acc_or, acc_and;
        bit exp_pass;
        row = srow; need = (nw > MAXW) ? MAXW : nw; idx = 0;
        acc_or = '0; acc_and = '1;
        while (need > 0 && row <= erow) begin
            exp_rows.push_back(row);
            if (!m_ecc[row % 64] && m_fail[row % 64] == '0) begin
                exp_keys.push_back({IDX_W'(idx), m_dat[row % 64]});
                acc_or  = acc_or | m_dat[row % 64];
                acc_and = acc_and & m_dat[row % 64];
                idx++; need--;
            end
            row++;
        end
        exp_pass = (acc_and != '1) && (acc_or != '0) && !(row > erow);

        @(negedge clk);
        start_row = ROW_W'(srow); end_row = ROW_W'(erow); num_words = CNT_W'(nw);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R1", "busy after start", busy, 1);
        if (mid_start) begin
            repeat (3) @(negedge clk);
            chk(busy, "R1", "busy before second start", busy, 1);
            start_row = 10'd40; num_words = 5'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cnt = 0;
        while (!done && cnt < 3000) begin
            @(negedge clk);
            cnt++;
        end
        chk(done, "R9", "done seen", done, 1);
        chk(pass == exp_pass, vtag, "verdict", pass, exp_pass);
        chk(!busy, "R9", "busy low with done", busy, 0);
        @(negedge clk);
        chk(!done, "R9", "done single cycle", done, 0);
        repeat (2) @(negedge clk);
        chk(pass == exp_pass, "R9", "pass held", pass, exp_pass);
        chk(exp_rows.size() == 0, "R2", "rows outstanding", exp_rows.size(), 0);
        chk(exp_keys.size() == 0, "R4", "words outstanding", exp_keys.size(), 0);
    endtask

    initial begin
        for (int r = 0; r < 64; r++) begin
            m_dat[r]  = 32'hA500_0000 | (r * 32'h0001_3579);
            m_ecc[r]  = 1'b0;
            m_fail[r] = '0;
        end
        m_ecc[11]  = 1'b1;
        m_fail[13] = 9'h100;
        m_fail[14] = 9'h001;
        m_ecc[21]  = 1'b1;
        for (int r = 30; r < 34; r++) m_dat[r] = '0;
        for (int r = 40; r < 43; r++) m_dat[r] = '1;

        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy, "R10", "busy", busy, 0);
        chk(!done, "R10", "done", done, 0);
        chk(!pass, "R10", "pass", pass, 0);
        chk(!rd_req, "R10", "rd_req", rd_req, 0);
        chk(!key_valid, "R10", "key_valid", key_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_case(0, 9, 4, "R2", 1'b0);        // clean rows, pass
        run_case(10, 19, 4, "R3", 1'b0);      // ecc and fail rows skipped
        run_case(20, 23, 4, "R8", 1'b0);      // range exhausted
        run_case(24, 27, 4, "R8", 1'b0);      // last word on end row
        run_case(30, 39, 2, "R7", 1'b0);      // blank key
        run_case(40, 49, 2, "R6", 1'b0);      // all-ones key
        run_case(0, 9, 4, "R11", 1'b0);       // fresh state after failures
        run_case(0, 9, 0, "R5", 1'b0);        // zero words
        run_case(0, 63, 20, "R5", 1'b0);      // clamp to MAX_WORDS
        run_case(0, 63, 6, "R1", 1'b1);       // start while busy ignored
        run_case(1020, 1023, 8, "R8", 1'b0);  // no wrap at top row
        run_case(5, 3, 4, "R8", 1'b0);        // end below start
        run_case(44, 60, 3, "R11", 1'b0);     // pass again

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule